// File: doc/BRIEF.md
# Quadrature IF Digital Downconverter

The block turns real intermediate-frequency samples from an external A/D converter into complex baseband. A single master clock drives everything. The block divides that clock by two to make the converter's sample clock. Each converted sample is captured on the matching internal strobe.

Each captured word is offset binary. It is re-centred to a signed value and multiplied by a cosine and a sine term from a numerically controlled oscillator, giving the in-phase and quadrature products. Each product stream passes through a short symmetric low-pass FIR that removes the sum-frequency image. The filter result is rounded and saturated, then presented as I and Q with a valid strobe.

With every output pair the block also presents a signed gain error: the sum of the magnitudes of I and Q, less a reference level. An external loop filter can use this value to steer the analogue gain ahead of the converter. The NCO frequency word sets the mixing frequency. A 10.7 MHz IF clocked from 26.97 MHz, or a 2.1 MHz IF clocked from 25.6 MHz, are typical settings.

Top module: `iq_downconverter`

## Requirements
- R1: While reset is asserted, adc_clk_o, iq_valid_o, i_o, q_o and gain_err_o are all zero.
- R2: Once reset has been released, adc_clk_o toggles on every master clock edge. iq_valid_o is a one-cycle pulse that occurs once per two master cycles.
- R3: A sample code c on adc_data_i (6 bits, offset binary) is taken as the signed value c-32. Codes 0, 32 and 63 therefore mean -32, 0 and +31. Words whose two low bits are zero (4-bit converters) follow the same rule.
- R4: The NCO keeps a 24-bit phase. The first captured sample after reset uses phase 0. Each later sample uses the previous phase plus the freq_word_i value sampled with that previous sample. The upper 8 phase bits form an address a. The sine term is +amp(m) in the first half cycle (a < 128) and -amp(m) in the second half. m is a mod 64 when bit 6 of a is clear, and 64 - (a mod 64) when it is set. amp(m) = floor(127*m*(128-m)/4096). The cosine term is the sine term at address a+64 (mod 256).
- R5: The in-phase product is sample times cosine term. The quadrature product is sample times sine term.
- R6: Each arm filters its product stream with weights 1,2,3,4,3,2,1. The output is floor((sum+32)/64), clamped to -512..511. Such a filter fully removes a tone at one quarter or one half of the sample rate.
- R7: gain_err_o (12-bit two's complement) equals |i_o| + |q_o| - gain_ref_i (11-bit unsigned). It changes only together with a new output pair, and i_o, q_o and gain_err_o hold while iq_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_data_i | input | 6 | Offset-binary sample from the A/D converter |
| freq_word_i | input | 24 | NCO phase increment per sample |
| gain_ref_i | input | 11 | Target level for the gain error |
| adc_clk_o | output | 1 | Converter sample clock, master clock divided by two |
| iq_valid_o | output | 1 | One-cycle strobe marking a new I/Q pair |
| i_o | output | 10 | In-phase baseband output, two's complement |
| q_o | output | 10 | Quadrature baseband output, two's complement |
| gain_err_o | output | 12 | Signed gain error for an external AGC loop |

## Verification
The embedded properties check the structural timing on every cycle. These are the divide-by-two sample clock and the isolated valid pulse. They also check that the outputs and the gain error stay frozen between strobes, that filter outputs move only after a tap shift, and that the oscillator never produces the asymmetric most-negative code. The arithmetic can only be shown by the directed scenarios, which compare settled outputs with values worked out by hand. This covers offset-binary decoding, the oscillator's folded amplitude at parked phases, mixer sign conventions, filter nulls at quarter and half sample rate, saturation at full scale, and the sign of the gain error.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  // symmetric low-pass: weights rise 1..4 then fall back
  localparam int FIR_TAPS   = 7;
  localparam int COEF_SUM_W = 4;  // weights sum to 16

  function automatic int fir_coef(input int k);
    return (k <= FIR_TAPS / 2) ? k + 1 : FIR_TAPS - k;
  endfunction
endpackage

// File: rtl/ddc_nco.sv
module ddc_nco
  import ddc_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int ADDR_W  = 8,
  parameter int TRIG_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_en,
  input  logic [PHASE_W-1:0]       freq_i,
  output logic signed [TRIG_W-1:0] cos_o,
  output logic signed [TRIG_W-1:0] sin_o
);
  localparam int HALF     = 2 ** (ADDR_W - 1);
  localparam int QUART    = 2 ** (ADDR_W - 2);
  localparam int AMAX     = 2 ** (TRIG_W - 1) - 1;
  localparam int SCALE_SH = 2 * ADDR_W - 4;

  // folded parabolic quarter-wave: distance from zero crossing, then sign
  function automatic logic signed [TRIG_W-1:0] wave(input logic [ADDR_W-1:0] a);
    int m;
    int amp;
    m   = a[ADDR_W-2] ? QUART - int'(a[ADDR_W-3:0]) : int'(a[ADDR_W-3:0]);
    amp = (AMAX * m * (HALF - m)) >>> SCALE_SH;
    return a[ADDR_W-1] ? TRIG_W'(-amp) : TRIG_W'(amp);
  endfunction

  logic [PHASE_W-1:0]       phase_q, phase_d;
  logic [ADDR_W-1:0]        addr, addr_c;
  logic signed [TRIG_W-1:0] sin_d, cos_d;

  assign addr   = phase_q[PHASE_W-1 -: ADDR_W];
  assign addr_c = addr + ADDR_W'(QUART);

  always_comb begin
    phase_d = phase_q + freq_i;
    sin_d   = wave(addr);
    cos_d   = wave(addr_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      sin_o   <= '0;
      cos_o   <= '0;
    end else if (step_en) begin
      phase_q <= phase_d;
      sin_o   <= sin_d;
      cos_o   <= cos_d;
    end
  end

  // R4: amplitude stays symmetric, the most negative code never appears
  p_trig_symmetric_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sin_o != {1'b1, {(TRIG_W-1){1'b0}}}) && (cos_o != {1'b1, {(TRIG_W-1){1'b0}}}));
endmodule

// File: rtl/ddc_fir.sv
module ddc_fir
  import ddc_pkg::*;
#(
  parameter int IN_W   = 14,
  parameter int OUT_W  = 10,
  parameter int RND_SH = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shift_en,
  input  logic signed [IN_W-1:0]  x_i,
  output logic signed [OUT_W-1:0] y_o
);
  localparam int ACC_W   = IN_W + COEF_SUM_W;
  localparam int OUT_MAX = 2 ** (OUT_W - 1) - 1;
  localparam int OUT_MIN = -(2 ** (OUT_W - 1));
  localparam logic signed [ACC_W-1:0] RND_ADD = ACC_W'(2 ** (RND_SH - 1));

  logic signed [IN_W-1:0]  tap_q [FIR_TAPS];
  logic signed [IN_W-1:0]  tap_d [FIR_TAPS];
  logic signed [ACC_W-1:0] acc, scaled;

  always_comb begin
    tap_d[0] = x_i;
    for (int k = 1; k < FIR_TAPS; k++) tap_d[k] = tap_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < FIR_TAPS; k++) tap_q[k] <= '0;
    end else if (shift_en) begin
      for (int k = 0; k < FIR_TAPS; k++) tap_q[k] <= tap_d[k];
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < FIR_TAPS; k++)
      acc = acc + ACC_W'(fir_coef(k)) * ACC_W'(tap_q[k]);
    scaled = (acc + RND_ADD) >>> RND_SH;
    if (scaled > OUT_MAX)      y_o = OUT_W'(OUT_MAX);
    else if (scaled < OUT_MIN) y_o = OUT_W'(OUT_MIN);
    else                       y_o = OUT_W'(scaled);
  end

  // R6: filter result moves only after a tap shift
  p_fir_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(y_o));
endmodule

// File: rtl/iq_downconverter.sv
module iq_downconverter
  import ddc_pkg::*;
#(
  parameter int IN_W    = 6,
  parameter int PHASE_W = 24,
  parameter int ADDR_W  = 8,
  parameter int TRIG_W  = 8,
  parameter int OUT_W   = 10,
  parameter int RND_SH  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [IN_W-1:0]          adc_data_i,
  input  logic [PHASE_W-1:0]       freq_word_i,
  input  logic [OUT_W:0]           gain_ref_i,
  output logic                     adc_clk_o,
  output logic                     iq_valid_o,
  output logic signed [OUT_W-1:0]  i_o,
  output logic signed [OUT_W-1:0]  q_o,
  output logic signed [OUT_W+1:0]  gain_err_o
);
  localparam int PROD_W = IN_W + TRIG_W;
  localparam int GERR_W = OUT_W + 2;

  logic rst_meta_q, rst_sync_q;
  logic div_q, v1_q, v2_q, v3_q;
  logic signed [IN_W-1:0]   x_q, x_d;
  logic signed [TRIG_W-1:0] cos_w, sin_w;
  logic signed [PROD_W-1:0] prod_q [2];
  logic signed [PROD_W-1:0] prod_d [2];
  logic signed [OUT_W-1:0]  arm_y [2];
  logic [OUT_W:0]           mag_sum;
  logic signed [GERR_W-1:0] gerr_d;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  function automatic logic [OUT_W:0] mag(input logic signed [OUT_W-1:0] v);
    return v[OUT_W-1] ? (OUT_W+1)'(-$signed({v[OUT_W-1], v})) : {1'b0, v};
  endfunction

  always_comb begin
    x_d       = {~adc_data_i[IN_W-1], adc_data_i[IN_W-2:0]};
    prod_d[0] = PROD_W'(x_q) * PROD_W'(cos_w);
    prod_d[1] = PROD_W'(x_q) * PROD_W'(sin_w);
    mag_sum   = mag(arm_y[0]) + mag(arm_y[1]);
    gerr_d    = $signed({1'b0, mag_sum}) - $signed({1'b0, gain_ref_i});
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      div_q      <= 1'b0;
      v1_q       <= 1'b0;
      v2_q       <= 1'b0;
      v3_q       <= 1'b0;
      iq_valid_o <= 1'b0;
      x_q        <= '0;
      prod_q[0]  <= '0;
      prod_q[1]  <= '0;
      i_o        <= '0;
      q_o        <= '0;
      gain_err_o <= '0;
    end else begin
      div_q      <= ~div_q;
      v1_q       <= div_q;
      v2_q       <= v1_q;
      v3_q       <= v2_q;
      iq_valid_o <= v3_q;
      if (div_q) x_q <= x_d;
      if (v1_q) begin
        prod_q[0] <= prod_d[0];
        prod_q[1] <= prod_d[1];
      end
      if (v3_q) begin
        i_o        <= arm_y[0];
        q_o        <= arm_y[1];
        gain_err_o <= gerr_d;
      end
    end
  end

  assign adc_clk_o = div_q;

  ddc_nco #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .TRIG_W(TRIG_W)) nco_i (
    .clk(clk), .rst_n(rst_sync_q), .step_en(div_q), .freq_i(freq_word_i),
    .cos_o(cos_w), .sin_o(sin_w)
  );

  for (genvar g = 0; g < 2; g++) begin : g_arm
    ddc_fir #(.IN_W(PROD_W), .OUT_W(OUT_W), .RND_SH(RND_SH)) fir_i (
      .clk(clk), .rst_n(rst_sync_q), .shift_en(v2_q), .x_i(prod_q[g]), .y_o(arm_y[g])
    );
  end

  // R2: sample clock alternates every master cycle
  p_adc_clk_toggle_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    1'b1 |=> (adc_clk_o != $past(adc_clk_o)));
  // R2: valid is never two cycles wide
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    iq_valid_o |=> !iq_valid_o);
  // R7: outputs and gain error frozen between strobes
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !iq_valid_o |-> ($stable(gain_err_o) && $stable(i_o) && $stable(q_o)));
endmodule

// File: tb/iq_downconverter_tb.sv
module iq_downconverter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  adc_data;
  logic [23:0] freq_word;
  logic [10:0] gain_ref;
  logic        adc_clk_o, iq_valid_o;
  logic signed [9:0]  i_o, q_o;
  logic signed [11:0] gain_err_o;
  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  iq_downconverter dut_i (
    .clk(clk), .rst_n(rst_n), .adc_data_i(adc_data), .freq_word_i(freq_word),
    .gain_ref_i(gain_ref), .adc_clk_o(adc_clk_o), .iq_valid_o(iq_valid_o),
    .i_o(i_o), .q_o(q_o), .gain_err_o(gain_err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R6 output scaling: round then clamp
  function automatic int scale(input int s);
    int r;
    r = (s + 32) >>> 6;
    if (r > 511) r = 511;
    if (r < -512) r = -512;
    return r;
  endfunction

  function automatic int amp(input int m);
    return (127 * m * (128 - m)) / 4096;
  endfunction

  function automatic int absv(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive n samples from a 4-long pattern, then read a settled output pair
  task automatic stream(input logic [5:0] d0, d1, d2, d3,
                        input logic [23:0] f_first, f_rest, input int n);
    logic [5:0] pat [4];
    pat = '{d0, d1, d2, d3};
    @(negedge clk);
    while (!adc_clk_o) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      adc_data  = pat[k % 4];
      freq_word = (k == 0) ? f_first : f_rest;
      if (k != n - 1) begin
        @(negedge clk);
        @(negedge clk);
      end
    end
    @(negedge clk);
    while (!iq_valid_o) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    adc_data = 6'd63; freq_word = 24'h400000; gain_ref = 11'd5;
    repeat (4) @(negedge clk);
    chk("R1 adc_clk", int'(adc_clk_o), 0);
    chk("R1 valid", int'(iq_valid_o), 0);
    chk("R1 i", int'(i_o), 0);
    chk("R1 q", int'(q_o), 0);
    chk("R1 gain_err", int'(gain_err_o), 0);
  endtask

  task automatic t_rate();
    int toggles = 0;
    int valids  = 0;
    logic prev;
    do_reset();
    repeat (10) @(negedge clk);
    prev = adc_clk_o;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (adc_clk_o != prev) toggles++;
      if (iq_valid_o) valids++;
      prev = adc_clk_o;
    end
    chk("R2 adc_clk toggles", toggles, 40);
    chk("R2 valid count", valids, 20);
  endtask

  // constant input, oscillator parked at phase 0: cosine 127, sine 0
  task automatic t_dc(input logic [5:0] code, input int ref_lvl, input string tag);
    int x, ei;
    do_reset();
    gain_ref = 11'(ref_lvl);
    stream(code, code, code, code, 24'd0, 24'd0, 40);
    x  = int'(code) - 32;
    ei = scale(x * 127 * 16);
    chk({tag, " i"}, int'(i_o), ei);
    chk({tag, " q"}, int'(q_o), 0);
    chk({tag, " R7 gain_err"}, int'(gain_err_o), absv(ei) - ref_lvl);
  endtask

  task automatic t_tone_null();
    do_reset();
    gain_ref = 11'd0;
    stream(6'd48, 6'd48, 6'd48, 6'd48, 24'h400000, 24'h400000, 40);
    chk("R6 quarter-rate null i", int'(i_o), 0);
    chk("R6 quarter-rate null q", int'(q_o), 0);
  endtask

  task automatic t_tone_mix();
    // x = 16,0,-16,0 against cosine 127,0,-127,0: I products 2032,0,2032,0
    do_reset();
    gain_ref = 11'd0;
    stream(6'd48, 6'd32, 6'd16, 6'd32, 24'h400000, 24'h400000, 40);
    chk("R5 cos-aligned i", int'(i_o), scale(8 * 127 * 16));
    chk("R5 cos-aligned q", int'(q_o), 0);
    chk("R7 tone gain_err", int'(gain_err_o), scale(8 * 127 * 16));
    // x = 0,16,0,-16 against sine 0,127,0,-127
    do_reset();
    stream(6'd32, 6'd48, 6'd32, 6'd16, 24'h400000, 24'h400000, 40);
    chk("R5 sin-aligned i", int'(i_o), 0);
    chk("R5 sin-aligned q", int'(q_o), scale(8 * 127 * 16));
  endtask

  // one step to address 32 or 160, then freeze the phase
  task automatic t_park(input logic [23:0] step, input int sgn, input string tag);
    int e;
    do_reset();
    gain_ref = 11'd0;
    stream(6'd48, 6'd48, 6'd48, 6'd48, step, 24'd0, 40);
    e = scale(16 * sgn * amp(32) * 16);
    chk({tag, " i"}, int'(i_o), e);
    chk({tag, " q"}, int'(q_o), e);
  endtask

  initial begin
    t_reset();
    t_rate();
    t_dc(6'd48, 200, "R3 R5 code48");
    t_dc(6'd48, 300, "R3 code48 low-level");
    t_dc(6'd0,  0,   "R6 code0 saturate");
    t_dc(6'd63, 0,   "R6 code63 saturate");
    t_dc(6'd32, 0,   "R3 code32 midscale");
    t_dc(6'd28, 0,   "R3 four-bit code");
    t_tone_null();
    t_tone_mix();
    t_park(24'h200000, 1,  "R4 park 45deg");
    t_park(24'hA00000, -1, "R4 park 225deg");
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule